// File: doc/BRIEF.md
# Dual Down-Counting Interval Timers

This peripheral holds two independent 32-bit interval timers behind a small register bus. Each timer has a reload value, a readable live count and a control word. The control word chooses an operation (load, hold or run) and one of four tick inputs. A running timer counts down by one on each selected tick. When it expires, it reloads itself and flags a pending interrupt. Tick sources arrive as single-cycle enable pulses; the block generates no clocks of its own.

A shared interrupt unit collects the two expiry flags into a pending word, at bit 0 for timer 0 and bit 1 for timer 1. It gates that word with a mask and drives one level interrupt line, which is high whenever any unmasked bit is pending. Software clears pending bits by writing ones to a self-clearing acknowledge location.

The bus is single-cycle. A write lands on the next clock edge. A read presents its data on `rd_data` one cycle after `rd_en` is sampled, and `rd_data` is zero in cycles with no read.

Top module: `dual_interval_timer`

## Requirements
- R1: Reset, synchronous and active high, clears every reload value, control word and count, the pending word and the mask, so `irq_o` and `rd_data` are low. Control word 0 selects no tick source, so no timer counts after reset.
- R2: Register map by byte offset. Timer 0 uses 0x00 for reload, 0x04 for count and 0x08 for control. Timer 1 uses 0x10, 0x14 and 0x18. The mask is at 0x48, acknowledge at 0x4C, raw pending at 0x50 and masked pending at 0x54. Control reads back its stored bits [4:0]. The mask and both pending words read as bits [1:0]. Any other offset reads zero.
- R3: Writing a control word whose bits [1:0] are 0 (load) copies that timer's reload value into its count on the write edge.
- R4: Operation codes 1 (hold) and 3 (reserved) leave the count unchanged, whatever the ticks do.
- R5: With operation code 2 (run), each selected tick does one of two things. If the count is greater than 1, the count decrements. If the count is 0 or 1, the count reloads from the reload value and the timer expires on that same edge.
- R6: Control bits [4:2] pick the tick source: code 4, 5, 6 or 7 selects `tick_i[0]`, `[1]`, `[2]` or `[3]`. Codes 0 to 3 select nothing, so the count does not move. Written bits above bit 4 are ignored.
- R7: An expiry of timer 0 sets pending bit 0, and an expiry of timer 1 sets pending bit 1.
- R8: A write to 0x4C clears each pending bit where the written value has a 1. The written value is not kept, so 0x4C reads zero. An expiry on the same edge as an acknowledge of its bit leaves the bit set.
- R9: Masked pending equals raw pending AND mask. `irq_o` is the OR of the masked pending bits and reflects a mask, acknowledge or expiry from the same edge at which that change takes effect.
- R10: In a cycle that writes a timer's control word, that timer ignores its tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | ADDR_W | Byte offset |
| wdata | input | DATA_W | Write data |
| tick_i | input | N_TICK | Tick enable pulses, one per source |
| rd_data | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt level |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit byte offset and four tick inputs. This brings every control code within reach, including the disabled source codes and the ignored upper control bits. It also allows a reload value of 1, which makes a timer expire on every tick. At that reload value an expiry can be made to coincide with an acknowledge or a control write. Counts, pending words and the interrupt are compared against a behavioural model on every clock.

// File: rtl/dit_pkg.sv
package dit_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_RSVD = 2'd3
  } tmr_op_e;

  localparam int N_TMR      = 2;
  localparam int CTRL_W     = 5;
  localparam int SEL_W      = 3;
  localparam int TMR_STRIDE = 16;
  localparam int OFS_RELOAD = 0;
  localparam int OFS_COUNT  = 4;
  localparam int OFS_CTRL   = 8;
  localparam int OFS_MASK   = 'h48;
  localparam int OFS_ACK    = 'h4C;
  localparam int OFS_RAW    = 'h50;
  localparam int OFS_MASKED = 'h54;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import dit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int N_TICK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload_we,
  input  logic              ctrl_we,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [N_TICK-1:0] tick_i,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              expire_o
);
  localparam int SRC_BASE = 4;

  tmr_op_e          op;
  logic [SEL_W-1:0] sel;
  logic             tick_sel;
  logic             step;

  assign op  = tmr_op_e'(ctrl_q[1:0]);
  assign sel = ctrl_q[CTRL_W-1:2];

  always_comb begin
    tick_sel = 1'b0;
    for (int k = 0; k < N_TICK; k++) begin
      if (sel == SEL_W'(SRC_BASE + k)) tick_sel = tick_i[k];
    end
  end

  assign step     = !ctrl_we && (op == OP_RUN) && tick_sel;
  assign expire_o = step && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (reload_we) reload_q <= wdata;
      if (ctrl_we) begin
        ctrl_q <= wdata[CTRL_W-1:0];
        if (tmr_op_e'(wdata[1:0]) == OP_LOAD) cnt_q <= reload_q;
      end else if (step) begin
        if (expire_o) cnt_q <= reload_q;
        else          cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && wdata[1:0] == 2'd0) |=> (cnt_q == $past(reload_q))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_we && (op == OP_HOLD || op == OP_RSVD)) |=> $stable(cnt_q)); // R4
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_q == $past(reload_q))); // R5
  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_we && !ctrl_q[CTRL_W-1]) |=> $stable(cnt_q)); // R6
  AST_CTRL_WINS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && wdata[1:0] != 2'd0) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] expire_i,
  input  logic             mask_we,
  input  logic             ack_we,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] mask_q,
  output logic             irq_o
);
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] pend_n;
  logic [N_SRC-1:0] mask_n;

  assign clr    = ack_we ? wdata : '0;
  assign pend_n = (pend_q & ~clr) | expire_i;
  assign mask_n = mask_we ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      mask_q <= mask_n;
      irq_o  <= |(pend_n & mask_n);
    end
  end

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit_chk
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
      expire_i[b] |=> pend_q[b]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (ack_we && wdata[b] && !expire_i[b]) |=> !pend_q[b]); // R8
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (pend_q == '0 && mask_q == '0 && !irq_o)); // R1
  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask_we && wdata == '0) |=> !irq_o); // R9
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_TICK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_TICK-1:0] tick_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  logic [DATA_W-1:0] reload_q [N_TMR];
  logic [CTRL_W-1:0] ctrl_q   [N_TMR];
  logic [DATA_W-1:0] cnt_q    [N_TMR];
  logic [N_TMR-1:0]  expire;
  logic [N_TMR-1:0]  pend_q;
  logic [N_TMR-1:0]  mask_q;
  logic              mask_we;
  logic              ack_we;
  logic [DATA_W-1:0] rd_mux;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    logic reload_we;
    logic ctrl_we;
    assign reload_we = wr_en && (addr == ADDR_W'(t * TMR_STRIDE + OFS_RELOAD));
    assign ctrl_we   = wr_en && (addr == ADDR_W'(t * TMR_STRIDE + OFS_CTRL));

    tmr_channel #(
      .CNT_W (DATA_W),
      .N_TICK(N_TICK)
    ) u_chan (
      .clk      (clk),
      .rst      (rst),
      .reload_we(reload_we),
      .ctrl_we  (ctrl_we),
      .wdata    (wdata),
      .tick_i   (tick_i),
      .reload_q (reload_q[t]),
      .ctrl_q   (ctrl_q[t]),
      .cnt_q    (cnt_q[t]),
      .expire_o (expire[t])
    );
  end

  assign mask_we = wr_en && (addr == ADDR_W'(OFS_MASK));
  assign ack_we  = wr_en && (addr == ADDR_W'(OFS_ACK));

  irq_unit #(
    .N_SRC(N_TMR)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .expire_i(expire),
    .mask_we (mask_we),
    .ack_we  (ack_we),
    .wdata   (wdata[N_TMR-1:0]),
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int t = 0; t < N_TMR; t++) begin
      if (addr == ADDR_W'(t * TMR_STRIDE + OFS_RELOAD)) rd_mux = reload_q[t];
      if (addr == ADDR_W'(t * TMR_STRIDE + OFS_COUNT))  rd_mux = cnt_q[t];
      if (addr == ADDR_W'(t * TMR_STRIDE + OFS_CTRL))   rd_mux = DATA_W'(ctrl_q[t]);
    end
    if (addr == ADDR_W'(OFS_MASK))   rd_mux = DATA_W'(mask_q);
    if (addr == ADDR_W'(OFS_RAW))    rd_mux = DATA_W'(pend_q);
    if (addr == ADDR_W'(OFS_MASKED)) rd_mux = DATA_W'(pend_q & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFS_ACK)) |=> (rd_data == '0)); // R8
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0)); // R2
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  tick = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit armed = 0;

  logic [31:0] m_rel [2];
  logic [31:0] m_ctl [2];
  logic [31:0] m_cnt [2];
  logic [1:0]  m_pend = '0;
  logic [1:0]  m_mask = '0;
  logic        exp_irq = 1'b0;
  logic [31:0] exp_rd = '0;

  always #4 clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tick_i(tick), .rd_data(rd_data), .irq_o(irq_o)
  );

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] v = '0;
    for (int t = 0; t < 2; t++) begin
      if (a == 16 * t)     v = m_rel[t];
      if (a == 16 * t + 4) v = m_cnt[t];
      if (a == 16 * t + 8) v = m_ctl[t];
    end
    if (a == 'h48) v = {30'd0, m_mask};
    if (a == 'h50) v = {30'd0, m_pend};
    if (a == 'h54) v = {30'd0, m_pend & m_mask};
    return v;
  endfunction

  always @(posedge clk) begin
    logic [1:0] fired;
    logic [1:0] ack;
    int sel;
    exp_rd = (rd_en && !rst) ? model_read(int'(addr)) : '0;
    if (rst) begin
      for (int t = 0; t < 2; t++) begin
        m_rel[t] = '0; m_ctl[t] = '0; m_cnt[t] = '0;
      end
      m_pend = '0; m_mask = '0; exp_irq = 1'b0;
    end else begin
      fired = '0;
      for (int t = 0; t < 2; t++) begin
        if (wr_en && int'(addr) == 16 * t + 8) begin
          m_ctl[t] = wdata & 32'h1F;
          if (wdata[1:0] == 2'd0) m_cnt[t] = m_rel[t];
        end else if (m_ctl[t][1:0] == 2'd2) begin
          sel = int'(m_ctl[t] >> 2);
          if (sel >= 4 && tick[sel-4]) begin
            if (m_cnt[t] <= 1) begin
              m_cnt[t] = m_rel[t];
              fired[t] = 1'b1;
            end else begin
              m_cnt[t] = m_cnt[t] - 1;
            end
          end
        end
        if (wr_en && int'(addr) == 16 * t) m_rel[t] = wdata;
      end
      ack = (wr_en && addr == 8'h4C) ? wdata[1:0] : 2'b00;
      m_pend = (m_pend & ~ack) | fired;
      if (wr_en && addr == 8'h48) m_mask = wdata[1:0];
      exp_irq = |(m_pend & m_mask);
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (irq_o !== exp_irq) begin
        failures++;
        $display("FAIL %s irq_o actual=%0b expected=%0b t=%0t", cur_req, irq_o, exp_irq, $time);
      end
      checks++;
      if (rd_data !== exp_rd) begin
        failures++;
        $display("FAIL %s rd_data actual=%h expected=%h t=%0t", cur_req, rd_data, exp_rd, $time);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  task automatic cyc(input bit we, input bit re, input int a, input logic [31:0] d, input logic [3:0] tk);
    wr_en = we; rd_en = re; addr = a[7:0]; wdata = d; tick = tk;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] tk = 4'd0);
    cyc(1'b1, 1'b0, a, d, tk);
  endtask

  task automatic rd(input int a, input logic [3:0] tk = 4'd0);
    cyc(1'b0, 1'b1, a, 32'd0, tk);
  endtask

  initial begin
    @(negedge clk);
    cyc(0, 1, 'h04, 0, 4'hF);
    cyc(0, 0, 0, 0, 0);
    rst = 1'b0;
    cur_req = "R1";
    rd('h04, 4'hF); rd('h14, 4'hF); rd('h48); rd('h50); rd('h54);

    cur_req = "R3";
    wr('h00, 32'd5);
    wr('h08, 32'd16);
    rd('h04); rd('h04, 4'hF);

    cur_req = "R2";
    rd('h00); rd('h08); rd('h30); rd('h5C); rd('h0C); rd('h10);

    cur_req = "R5";
    wr('h08, 32'd18);
    for (int i = 0; i < 16; i++) rd((i % 2) ? 'h50 : 'h04, (i % 2) ? 4'h0 : 4'h1);

    cur_req = "R9";
    wr('h48, 32'd1);
    rd('h54); rd('h54);
    wr('h48, 32'd0);
    rd('h54); rd('h48);

    cur_req = "R8";
    wr('h48, 32'd3);
    wr('h4C, 32'd1);
    rd('h4C); rd('h50); rd('h54);

    cur_req = "R4";
    wr('h08, 32'd17);
    for (int i = 0; i < 5; i++) rd('h04, 4'hF);
    wr('h08, 32'd19);
    for (int i = 0; i < 5; i++) rd('h04, 4'hF);

    cur_req = "R6";
    wr('h10, 32'd3);
    wr('h18, 32'd28);
    wr('h18, 32'd30);
    for (int i = 0; i < 5; i++) rd('h14, 4'h1);
    for (int i = 0; i < 8; i++) rd((i % 3 == 2) ? 'h50 : 'h14, 4'h8);
    wr('h4C, 32'd3);
    wr('h18, 32'd10);
    for (int i = 0; i < 5; i++) rd('h14, 4'hF);
    wr('h18, 32'hFFFF_FF1E);
    rd('h18, 4'hF);
    for (int i = 0; i < 4; i++) rd('h14, 4'hF);

    cur_req = "R10";
    wr('h18, 32'd30, 4'hF);
    rd('h14); rd('h14, 4'h8); rd('h14);

    cur_req = "R7";
    wr('h10, 32'd1);
    wr('h4C, 32'd3);
    rd('h50, 4'h8); rd('h50);

    cur_req = "R8";
    wr('h4C, 32'd2, 4'h8);
    rd('h50); rd('h54);
    wr('h4C, 32'd2);
    rd('h50);

    cur_req = "R1";
    rd('h14, 4'h8);
    rst = 1'b1;
    rd('h14, 4'hF); rd('h14, 4'hF);
    rst = 1'b0;
    rd('h14, 4'hF); rd('h10); rd('h50); rd('h48);
    cyc(0, 0, 0, 0, 0);

    finish_run();
  end
endmodule